// File: doc/BRIEF.md
# Decimating Exponential Smoothing Filter

This block smooths a stream of signed converter samples with a first-order exponential average and lowers the output rate by four. Each accepted sample moves an internal accumulator one quarter of the way toward the new sample. The move is a subtract, an arithmetic right shift by two and an add. Every fourth accepted sample, the block publishes the negated accumulator and advances a 32-bit frame number. It also raises a one-clock strobe so that downstream logic can capture the pair.

After reset the block makes one publication before any sample arrives. That publication carries a value of zero and the frame start value of -60000. Consumers therefore see a defined value and frame number from the first clock. Samples arrive with a valid strobe. Cycles without the strobe leave every piece of state unchanged.

Top module: `decim_smoother`

## Requirements
- R1: While rst_ni is low, publish_o is 0, avg_o is 0 and frame_o is -60000 as a 32-bit two's-complement value (32'hFFFF15A0).
- R2: On the first rising clock edge after rst_ni goes high, publish_o is 1 for that cycle with avg_o = 0 and frame_o = -60000.
- R3: On each cycle with sample_valid_i = 1, the 32-bit signed accumulator becomes acc + ((sign-extended sample_i − acc) >>> 2), where >>> rounds toward minus infinity. The accumulator starts at 0 after reset.
- R4: publish_o is 1 for exactly one cycle, on the clock edge that accepts every fourth valid sample counted from reset. It is 0 on all other cycles except the R2 pulse.
- R5: At a publication, avg_o is the two's-complement negation of the accumulator after the update from that fourth sample.
- R6: frame_o increases by exactly 1 at each publication that follows a fourth sample. It does not change at the R2 pulse.
- R7: avg_o and frame_o hold their values on every cycle where publish_o is 0.
- R8: A cycle with sample_valid_i = 0 changes neither the accumulator nor the sample count, whatever sample_i carries.
- R9: With 12-bit inputs, avg_o always lies in the range -2047 to 2048, including under long full-scale runs of either sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 12 | Signed input sample |
| sample_valid_i | input | 1 | Sample accepted on this edge when high |
| avg_o | output | 32 | Negated smoothed value, signed |
| frame_o | output | 32 | Frame number, signed, starting at -60000 |
| publish_o | output | 1 | One-cycle strobe marking a new avg_o/frame_o pair |

## Verification
All results are registered on the same edge that accepts the fourth valid sample. publish_o, avg_o and frame_o therefore change one clock edge after the sample is driven, and the startup pulse appears on the first edge after reset is released. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge. On every accepted or ignored sample it compares the strobe, the value and the frame number against a running model, so any early, late or stray change shows up in the cycle where it happens.

// File: rtl/esf_pkg.sv
package esf_pkg;
  localparam int unsigned SAMPLE_W_DEF = 12;
  localparam int unsigned ACC_W_DEF    = 32;
  localparam int unsigned FRAME_W_DEF  = 32;
  localparam int unsigned SHIFT_DEF    = 2;
  localparam int unsigned DECIM_DEF    = 4;
  localparam int          FRAME_START_DEF = -60000;
endpackage

// File: rtl/esf_smooth_acc.sv
module esf_smooth_acc #(
  parameter int unsigned SAMPLE_W = esf_pkg::SAMPLE_W_DEF,
  parameter int unsigned ACC_W    = esf_pkg::ACC_W_DEF,
  parameter int unsigned SHIFT    = esf_pkg::SHIFT_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic signed [ACC_W-1:0]    acc_next_o
);
  localparam int unsigned EXT_W = ACC_W - SAMPLE_W;

  logic signed [ACC_W-1:0] acc_q, ext, diff, step;

  assign ext  = {{EXT_W{sample_i[SAMPLE_W-1]}}, sample_i};
  assign diff = ext - acc_q;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign step = diff;
    end else begin : g_shift
      assign step = diff >>> SHIFT;
    end
  endgenerate

  assign acc_next_o = acc_q + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_next_o;
  end
endmodule

// File: rtl/esf_decim_ctr.sv
module esf_decim_ctr #(
  parameter int unsigned DECIM = esf_pkg::DECIM_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(DECIM + 1);

  generate
    if (DECIM <= 1) begin : g_every
      assign tick_o = en_i;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign tick_o = en_i && (cnt_q == CW'(1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= CW'(DECIM);
        else if (tick_o) cnt_q <= CW'(DECIM);
        else if (en_i)   cnt_q <= cnt_q - CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/esf_pub_stage.sv
module esf_pub_stage #(
  parameter int unsigned ACC_W       = esf_pkg::ACC_W_DEF,
  parameter int unsigned FRAME_W     = esf_pkg::FRAME_W_DEF,
  parameter int          FRAME_START = esf_pkg::FRAME_START_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pub_i,
  input  logic signed [ACC_W-1:0] value_i,
  output logic signed [ACC_W-1:0] avg_o,
  output logic [FRAME_W-1:0]      frame_o,
  output logic                    publish_o
);
  logic boot_q;  // one startup publication

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q    <= 1'b1;
      publish_o <= 1'b0;
      avg_o     <= '0;
      frame_o   <= FRAME_W'(FRAME_START);
    end else begin
      boot_q    <= 1'b0;
      publish_o <= boot_q | pub_i;
      if (pub_i) begin
        avg_o   <= -value_i;
        frame_o <= frame_o + FRAME_W'(1);
      end
    end
  end
endmodule

// File: rtl/decim_smoother.sv
module decim_smoother #(
  parameter int unsigned SAMPLE_W    = esf_pkg::SAMPLE_W_DEF,
  parameter int unsigned ACC_W       = esf_pkg::ACC_W_DEF,
  parameter int unsigned FRAME_W     = esf_pkg::FRAME_W_DEF,
  parameter int unsigned SHIFT       = esf_pkg::SHIFT_DEF,
  parameter int unsigned DECIM       = esf_pkg::DECIM_DEF,
  parameter int          FRAME_START = esf_pkg::FRAME_START_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       sample_valid_i,
  output logic signed [ACC_W-1:0]    avg_o,
  output logic [FRAME_W-1:0]         frame_o,
  output logic                       publish_o
);
  logic signed [ACC_W-1:0] acc_next;
  logic                    tick;

  esf_smooth_acc #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) i_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (sample_valid_i),
    .sample_i  (sample_i),
    .acc_next_o(acc_next)
  );

  esf_decim_ctr #(.DECIM(DECIM)) i_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sample_valid_i),
    .tick_o(tick)
  );

  esf_pub_stage #(.ACC_W(ACC_W), .FRAME_W(FRAME_W), .FRAME_START(FRAME_START)) i_pub (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pub_i    (tick),
    .value_i  (acc_next),
    .avg_o    (avg_o),
    .frame_o  (frame_o),
    .publish_o(publish_o)
  );
endmodule

// File: rtl/decim_smoother_chk.sv
module decim_smoother_chk #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned FRAME_W  = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sample_valid_i,
  input logic signed [ACC_W-1:0] avg_o,
  input logic [FRAME_W-1:0]      frame_o,
  input logic                    publish_o
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'(1) <<< (SAMPLE_W - 1);
  localparam logic signed [ACC_W-1:0] LO = -(HI - ACC_W'(1));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    publish_o |=> !publish_o);

  a_r6_frame_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_o) |-> frame_o == $past(frame_o) + FRAME_W'(1));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !publish_o |-> ($stable(avg_o) && $stable(frame_o)));

  a_r4_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_o) |-> ($past(sample_valid_i) && publish_o));

  a_r9_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avg_o >= LO) && (avg_o <= HI));
endmodule

bind decim_smoother decim_smoother_chk #(
  .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .FRAME_W(FRAME_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_valid_i(sample_valid_i),
  .avg_o         (avg_o),
  .frame_o       (frame_o),
  .publish_o     (publish_o)
);

// File: tb/test_decim_smoother.sv
module test_decim_smoother;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [11:0] sample_i = '0;
  logic               sample_valid_i = 1'b0;
  logic signed [31:0] avg_o;
  logic [31:0]        frame_o;
  logic               publish_o;

  int checks = 0, errors = 0;
  int m_acc, m_cnt, m_frame, m_avg;
  bit m_pub;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  decim_smoother i_decim_smoother (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i),
    .sample_valid_i(sample_valid_i), .avg_o(avg_o),
    .frame_o(frame_o), .publish_o(publish_o)
  );

  // {expected strobe, valid, sample}
  localparam logic [13:0] VEC [16] = '{
    {1'b0, 1'b1, 12'h3E8}, {1'b0, 1'b1, 12'h3E8}, {1'b0, 1'b0, 12'h800},
    {1'b0, 1'b1, 12'h3E8}, {1'b1, 1'b1, 12'h3E8}, {1'b0, 1'b1, 12'hE0C},
    {1'b0, 1'b0, 12'h7FF}, {1'b0, 1'b0, 12'h7FF}, {1'b0, 1'b1, 12'hE0C},
    {1'b0, 1'b1, 12'hE0C}, {1'b1, 1'b1, 12'hE0C}, {1'b0, 1'b1, 12'h7FF},
    {1'b0, 1'b1, 12'h800}, {1'b0, 1'b1, 12'h007}, {1'b1, 1'b1, 12'hFFF},
    {1'b0, 1'b0, 12'h000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)",
               req, $signed(act), act, $signed(exp), exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_cnt = 4; m_frame = -60000; m_avg = 0;
  endtask

  // drive at negedge, sample 1 ns after the next posedge
  task automatic apply(bit v, logic signed [11:0] s);
    int diff;
    @(negedge clk_i);
    sample_valid_i = v;
    sample_i = s;
    @(posedge clk_i);
    #1;
    m_pub = 1'b0;
    if (v) begin
      diff  = int'(s) - m_acc;
      m_acc = m_acc + (diff >>> 2);  // R3
      m_cnt--;
      if (m_cnt == 0) begin
        m_cnt = 4; m_frame++; m_pub = 1'b1; m_avg = -m_acc;
      end
    end
    chk("R4 strobe", 32'(publish_o), 32'(m_pub));
    chk(v ? "R5 value" : "R8 ignored value", avg_o, m_avg);
    chk(m_pub ? "R6 frame" : "R7 hold frame", frame_o, m_frame);
    chk("R9 range", 32'((avg_o >= -2047) && (avg_o <= 2048)), 32'd1);
  endtask

  task automatic do_reset_and_boot();
    @(negedge clk_i);
    rst_ni = 1'b0;
    sample_valid_i = 1'b0;
    model_reset();
    @(posedge clk_i);
    #1;
    chk("R1 publish", 32'(publish_o), 32'd0);
    chk("R1 avg", avg_o, 32'd0);
    chk("R1 frame", frame_o, 32'hFFFF15A0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    chk("R2 pulse", 32'(publish_o), 32'd1);
    chk("R2 avg", avg_o, 32'd0);
    chk("R2 frame", frame_o, 32'hFFFF15A0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    do_reset_and_boot();

    // table walk: R3 R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      apply(VEC[i][12], VEC[i][11:0]);
      chk("R4 table strobe", 32'(publish_o), 32'(VEC[i][13]));
    end

    // full-scale positive and negative runs: R9
    for (int k = 0; k < 40; k++) apply(1'b1, 12'sh7FF);
    for (int k = 0; k < 40; k++) apply(1'b1, -12'sh800);

    // invalid cycles with garbage between valid samples: R8
    for (int k = 0; k < 6; k++) begin
      apply(1'b0, 12'sh5A5);
      apply(1'b1, 12'sd300);
    end

    // reset mid-window reloads counter, accumulator, frame: R1 R2
    apply(1'b1, 12'sd900);
    apply(1'b1, 12'sd900);
    do_reset_and_boot();
    for (int k = 0; k < 4; k++) apply(1'b1, 12'sd100);
    chk("R6 frame after reset", frame_o, 32'hFFFF15A1);
    chk("R5 value after reset", avg_o, 32'(-m_acc));

    @(negedge clk_i);
    sample_valid_i = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule